// File: doc/BRIEF.md
# Remote Core Start Controller

This block lets one processor in a multiprocessor cluster bring another processor out of halt at an address of its choosing. Software on the controlling core writes through a small auxiliary register port. One register holds a parameter word. The other takes command words, and each command names a target core and an operation. For every core the block keeps a start-address register and a halt flag. It drives, per core, the stored start address, a one-cycle load strobe and the current halt state.

A core is woken in three writes. The first places the start address in the parameter register. The second issues a load-start-address command for the target. The third issues a release-from-halt command for the same target. Loading the address and releasing the halt are separate commands, so a core can be given a new address and released later. Commands aimed at a core that does not exist, and commands with an opcode that has no meaning, leave every output unchanged.

Top module: `remote_start_ctrl`

## Requirements
- R1: After a synchronous active-low reset, core 0 is running and every other core is halted (core_halted = all ones except bit 0). Every start address reads zero, no load strobe is active, and rd_data reads zero.
- R2: A write with wr_sel = 1 stores wr_data in the parameter register, and rd_data shows it from the cycle after the write. Command writes (wr_sel = 0) never change rd_data.
- R3: A command write (wr_sel = 0) with opcode 0x04 in bits [7:0] and target index T in bits [15:8] copies the parameter register into the start address of core T. The new address appears on that core's slice of core_pc in the cycle after the write, and core_pc_load[T] is high for exactly that one cycle.
- R4: A command with opcode 0x02 clears the halt flag of core T in the cycle after the write. Releasing a core that is already running leaves it running. Only reset can set a halt flag.
- R5: A command whose target index is equal to or greater than NUM_CORES has no effect on any output.
- R6: A command whose opcode is neither 0x04 nor 0x02 (for example 0x00 or 0x05) has no effect on any output.
- R7: A command changes only its target core: the start addresses, strobes and halt flags of other cores are unchanged.
- R8: A load-start-address command leaves the target's halt flag unchanged, and a release command leaves the target's start address unchanged.
- R9: Bits [31:16] of a command word are not decoded, so any value there gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 = parameter register, 0 = command register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Parameter register read-back |
| core_pc | output | NUM_CORES*PC_W | Start address per core, core c in bits [c*PC_W +: PC_W] |
| core_pc_load | output | NUM_CORES | One-cycle start-address load strobe per core |
| core_halted | output | NUM_CORES | Halt flag per core, 1 = halted |

## Verification
The bench targets target indices just past the last core. A decoder that ignores the range check would alias the index back onto core 0 or write a phantom core, and would then change core 0's address or halt flag. Undefined opcodes and nonzero upper command bits are used to catch a decoder that matches on too few bits, because such a decoder would release or reload a core by mistake. The strobe is checked both in its active cycle and in the idle cycle after it, which exposes a level that stays high or a strobe that arrives one cycle late. Releasing an already running core, and loading an address without a release, expose a halt flag that toggles instead of clearing, or an address write that also frees the core.

// File: rtl/rcs_pkg.sv
// Package: shared field positions and opcodes of the remote core start controller.
// Assumes a command word carries the opcode in its low byte and the target core index
// in the byte above it; all higher bits are unused.
package rcs_pkg;
    localparam int OP_LSB  = 0;
    localparam int OP_W    = 8;
    localparam int TGT_LSB = 8;
    localparam int TGT_W   = 8;
    localparam int CMD_USED_W = TGT_LSB + TGT_W;

    localparam logic [OP_W-1:0] OP_LOAD_PC      = 8'h04;
    localparam logic [OP_W-1:0] OP_RELEASE_HALT = 8'h02;

    // Per-core action requested by one decoded command.
    typedef struct packed {
        logic load_pc;
        logic release_halt;
    } core_act_t;
endpackage

// File: rtl/rcs_cmd_decode.sv
// Module: rcs_cmd_decode
// Turns one command write into per-core action requests. At most one core receives an
// action per command. An index outside 0..NUM_CORES-1 matches no core, and an
// unknown opcode requests no action, so both fall through with no effect.
// Assumes NUM_CORES fits the target field (at most 256).
module rcs_cmd_decode
    import rcs_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                  cmd_valid,
    input  logic [CMD_USED_W-1:0] cmd_word,
    output core_act_t             act [NUM_CORES]
);
    logic [OP_W-1:0]  opcode;
    logic [TGT_W-1:0] target;
    logic             is_load;
    logic             is_release;

    // Split the command word into its fields and classify the opcode.
    always_comb begin
        opcode     = cmd_word[OP_LSB +: OP_W];
        target     = cmd_word[TGT_LSB +: TGT_W];
        is_load    = cmd_valid && (opcode == OP_LOAD_PC);
        is_release = cmd_valid && (opcode == OP_RELEASE_HALT);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_match
        logic hit;
        // Steer the action to the single core whose index equals the target field.
        always_comb begin
            hit                   = (target == TGT_W'(c));
            act[c].load_pc        = is_load && hit;
            act[c].release_halt   = is_release && hit;
        end
    end
endmodule

// File: rtl/rcs_param_reg.sv
// Module: rcs_param_reg
// Holds the parameter word that software writes ahead of a command. The value is
// readable at all times and changes only when a parameter write occurs.
module rcs_param_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_param,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] param_q
);
    // Capture a parameter write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        param_q <= '0;
        else if (wr_param) param_q <= wr_data;
    end
endmodule

// File: rtl/rcs_core_slot.sv
// Module: rcs_core_slot
// State for one remote core: its start address, a one-cycle load strobe and its halt
// flag. A load request copies the given address and raises the strobe for the next
// cycle only. A release request clears the halt flag, and only reset sets it again.
// HALT_AT_RESET selects whether this core starts out halted.
module rcs_core_slot #(
    parameter int PC_W          = 32,
    parameter bit HALT_AT_RESET = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_req,
    input  logic            release_req,
    input  logic [PC_W-1:0] load_addr,
    output logic [PC_W-1:0] pc_q,
    output logic            load_q,
    output logic            halted_q
);
    // Store the start address when a load request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (load_req) pc_q <= load_addr;
    end

    // Raise the load strobe for exactly the cycle after a load request.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load_req;
    end

    // Hold the halt flag; a release request clears it permanently until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           halted_q <= HALT_AT_RESET;
        else if (release_req) halted_q <= 1'b0;
    end
endmodule

// File: rtl/remote_start_ctrl.sv
// Module: remote_start_ctrl
// Remote core start controller. A controlling core writes a parameter word and then
// command words through one write port. Each command selects a target core and either
// loads that core's start address from the parameter word or releases it from halt.
// Core 0 leaves reset running and all other cores leave it halted.
// Assumes PC_W <= DATA_W and NUM_CORES <= 256. Writes take effect on the next edge.
module remote_start_ctrl
    import rcs_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int PC_W      = 32,
    parameter int DATA_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_CORES*PC_W-1:0] core_pc,
    output logic [NUM_CORES-1:0]      core_pc_load,
    output logic [NUM_CORES-1:0]      core_halted
);
    localparam int PC_BUS_W = NUM_CORES * PC_W;

    logic              wr_param;
    logic              wr_cmd;
    logic [DATA_W-1:0] param_q;
    core_act_t         act [NUM_CORES];
    logic [PC_W-1:0]   load_addr;

    // Split the write port between the parameter and command registers.
    always_comb begin
        wr_param  = wr_en && wr_sel;
        wr_cmd    = wr_en && !wr_sel;
        load_addr = param_q[PC_W-1:0];
    end

    rcs_param_reg #(
        .DATA_W (DATA_W)
    ) u_param (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_param (wr_param),
        .wr_data  (wr_data),
        .param_q  (param_q)
    );

    rcs_cmd_decode #(
        .NUM_CORES (NUM_CORES)
    ) u_decode (
        .cmd_valid (wr_cmd),
        .cmd_word  (wr_data[CMD_USED_W-1:0]),
        .act       (act)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        rcs_core_slot #(
            .PC_W          (PC_W),
            .HALT_AT_RESET (c != 0)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_req    (act[c].load_pc),
            .release_req (act[c].release_halt),
            .load_addr   (load_addr),
            .pc_q        (core_pc[c*PC_W +: PC_W]),
            .load_q      (core_pc_load[c]),
            .halted_q    (core_halted[c])
        );
    end

    // Read back the parameter register.
    always_comb rd_data = param_q;

    if (PC_BUS_W < PC_W) begin : g_bad_cfg
        $error("remote_start_ctrl: NUM_CORES must be at least 1");
    end
endmodule

// File: rtl/remote_start_ctrl_checker.sv
// Module: remote_start_ctrl_checker
// Property checks on the remote core start controller, attached by bind. Every check
// relates an output change to the write that must have caused it one cycle earlier.
module remote_start_ctrl_checker #(
    parameter int NUM_CORES = 4,
    parameter int PC_W      = 32,
    parameter int DATA_W    = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      wr_sel,
    input logic [DATA_W-1:0]         wr_data,
    input logic [DATA_W-1:0]         rd_data,
    input logic [NUM_CORES*PC_W-1:0] core_pc,
    input logic [NUM_CORES-1:0]      core_pc_load,
    input logic [NUM_CORES-1:0]      core_halted
);
    logic past_valid;

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // R2: rd_data moves only after a parameter write.
    assert_param_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        !$stable(rd_data) |-> $past(wr_en && wr_sel));

    // R2: a parameter write is visible on the next cycle.
    assert_param_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (rd_data == $past(wr_data)));

    // R7: no more than one core is strobed at a time.
    assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_pc_load));

    // R4: a halt flag is never set outside reset.
    assert_halt_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
        (core_halted & ~$past(core_halted)) == '0);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_per_core
        // R3: a core's address changes only after a load command aimed at it.
        assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
            !$stable(core_pc[c*PC_W +: PC_W]) |->
            $past(wr_en && !wr_sel && wr_data[7:0] == 8'h04 && wr_data[15:8] == 8'(c)));

        // R3: the strobe follows a load command aimed at this core.
        assert_load_cause_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
            core_pc_load[c] |->
            $past(wr_en && !wr_sel && wr_data[7:0] == 8'h04 && wr_data[15:8] == 8'(c)));

        // R4: a halt flag clears only after a release command aimed at it.
        assert_halt_cause_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_valid)
            !$stable(core_halted[c]) |->
            $past(wr_en && !wr_sel && wr_data[7:0] == 8'h02 && wr_data[15:8] == 8'(c)));
    end
endmodule

bind remote_start_ctrl remote_start_ctrl_checker #(
    .NUM_CORES (NUM_CORES),
    .PC_W      (PC_W),
    .DATA_W    (DATA_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .core_pc      (core_pc),
    .core_pc_load (core_pc_load),
    .core_halted  (core_halted)
);

// File: tb/remote_start_ctrl_test.sv
module remote_start_ctrl_test;
    localparam int NC = 4;
    localparam int PW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic        sel;       // 1 = parameter write, 0 = command write
        logic [31:0] data;
        logic [3:0]  req;       // requirement number, for the message
        logic [3:0]  exp_halt;
        logic [3:0]  exp_load;
        logic [1:0]  pc_core;   // core whose address is checked
        logic [31:0] exp_pc;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_1000, 4'd2, 4'b1110, 4'b0000, 2'd1, 32'h0000_0000, 32'h0000_1000}, // R2
        '{1'b0, 32'h0000_0104, 4'd3, 4'b1110, 4'b0010, 2'd1, 32'h0000_1000, 32'h0000_1000}, // R3 load core1
        '{1'b0, 32'h0000_0102, 4'd8, 4'b1100, 4'b0000, 2'd1, 32'h0000_1000, 32'h0000_1000}, // R8 release keeps pc
        '{1'b1, 32'h2000_0040, 4'd2, 4'b1100, 4'b0000, 2'd1, 32'h0000_1000, 32'h2000_0040}, // R2
        '{1'b0, 32'h0000_0304, 4'd8, 4'b1100, 4'b1000, 2'd3, 32'h2000_0040, 32'h2000_0040}, // R8 load keeps halt
        '{1'b0, 32'h0000_0404, 4'd5, 4'b1100, 4'b0000, 2'd0, 32'h0000_0000, 32'h2000_0040}, // R5 index 4
        '{1'b0, 32'h0000_0402, 4'd5, 4'b1100, 4'b0000, 2'd0, 32'h0000_0000, 32'h2000_0040}, // R5 index 4
        '{1'b0, 32'h0000_FF02, 4'd5, 4'b1100, 4'b0000, 2'd0, 32'h0000_0000, 32'h2000_0040}, // R5 index 255
        '{1'b0, 32'h0000_0305, 4'd6, 4'b1100, 4'b0000, 2'd3, 32'h2000_0040, 32'h2000_0040}, // R6 op 0x05
        '{1'b0, 32'h0000_0200, 4'd6, 4'b1100, 4'b0000, 2'd2, 32'h0000_0000, 32'h2000_0040}, // R6 op 0x00
        '{1'b0, 32'hABCD_0302, 4'd9, 4'b0100, 4'b0000, 2'd3, 32'h2000_0040, 32'h2000_0040}, // R9 upper bits
        '{1'b0, 32'h0000_0002, 4'd4, 4'b0100, 4'b0000, 2'd0, 32'h0000_0000, 32'h2000_0040}, // R4 already running
        '{1'b0, 32'h0000_0004, 4'd3, 4'b0100, 4'b0001, 2'd0, 32'h2000_0040, 32'h2000_0040}, // R3 load core0
        '{1'b1, 32'hFFFF_FFFC, 4'd7, 4'b0100, 4'b0000, 2'd3, 32'h2000_0040, 32'hFFFF_FFFC}, // R7 core3 kept
        '{1'b0, 32'h0000_0204, 4'd7, 4'b0100, 4'b0100, 2'd1, 32'h0000_1000, 32'hFFFF_FFFC}, // R7 core1 kept
        '{1'b0, 32'h0000_0202, 4'd4, 4'b0000, 4'b0000, 2'd2, 32'hFFFF_FFFC, 32'hFFFF_FFFC}  // R4 release core2
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [DW-1:0]     wr_data = '0;
    logic [DW-1:0]     rd_data;
    logic [NC*PW-1:0]  core_pc;
    logic [NC-1:0]     core_pc_load;
    logic [NC-1:0]     core_halted;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    remote_start_ctrl #(.NUM_CORES(NC), .PC_W(PW), .DATA_W(DW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .core_pc      (core_pc),
        .core_pc_load (core_pc_load),
        .core_halted  (core_halted)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One write, starting at a falling edge; returns at the next falling edge.
    task automatic write(input logic sel, input logic [31:0] data);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 halted", 32'(core_halted), 32'h0000_000E);
        check("R1 load", 32'(core_pc_load), 32'h0);
        check("R1 pc", core_pc[31:0] | core_pc[63:32] | core_pc[95:64] | core_pc[127:96], 32'h0);
        check("R1 rd", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            write(VECS[v].sel, VECS[v].data);
            check($sformatf("vector %0d R%0d halted", v, VECS[v].req), 32'(core_halted), 32'(VECS[v].exp_halt));
            check($sformatf("vector %0d R%0d load", v, VECS[v].req), 32'(core_pc_load), 32'(VECS[v].exp_load));
            check($sformatf("vector %0d R%0d pc", v, VECS[v].req),
                  core_pc[VECS[v].pc_core*PW +: PW], VECS[v].exp_pc);
            check($sformatf("vector %0d R%0d rd", v, VECS[v].req), rd_data, VECS[v].exp_rd);
        end

        // R3: strobe lasts one cycle and the address stays
        write(1'b1, 32'h0000_8000);
        write(1'b0, 32'h0000_0304);
        check("R3 strobe on", 32'(core_pc_load), 32'h8);
        check("R3 pc core3", core_pc[3*PW +: PW], 32'h0000_8000);
        @(negedge clk);
        check("R3 strobe off", 32'(core_pc_load), 32'h0);
        check("R3 pc held", core_pc[3*PW +: PW], 32'h0000_8000);

        // R2: command write does not change the read-back value
        check("R2 rd after cmd", rd_data, 32'h0000_8000);

        // R1: reset in mid-operation restores the reset state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 re-reset halted", 32'(core_halted), 32'h0000_000E);
        check("R1 re-reset pc3", core_pc[3*PW +: PW], 32'h0);
        check("R1 re-reset rd", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: a load to a halted core does not release it; the release is separate
        write(1'b1, 32'h0000_0ABC);
        write(1'b0, 32'h0000_0204);
        check("R8 still halted", 32'(core_halted), 32'h0000_000E);
        write(1'b0, 32'h0000_0202);
        check("R8 released", 32'(core_halted), 32'h0000_000A);
        check("R8 pc kept", core_pc[2*PW +: PW], 32'h0000_0ABC);

        finish_run();
    end
endmodule